// File: doc/BRIEF.md
# Link Self-Test Receive Checker

This block sits at the parallel output of a 24-bit serial link receiver and runs the receive half of an at-speed self-test. When the link is locked and the self-test enable is high, it takes the first received word as the seed for a local 7-bit pseudo-random generator. It then compares every later word against the word that generator predicts. With the enable low, received words go to the outputs unchanged.

Results appear on the same 24 data outputs in one of two ways, picked by a mode input. In map mode each output bit flags a mismatch at that bit position in the current word. In count mode the low eight bits carry a saturating running total of mismatched bits. A pass flag drops on the first error and stays low until the test is stopped. The output-enable signals for the data and the clock follow the lock indication.

The controller has two states. `ST_IDLE` passes data through. `ST_CHECK` compares words against the pattern. The transition `seed` (IDLE to CHECK) happens on the first edge where enable and lock are both high. The transition `stop` (CHECK to IDLE) happens on any edge where either of them is low.

Top module: `bist_rx_checker`

## Requirements
- R1: A synchronous active-high reset clears `dout` to zero, sets `pass_ok` high, clears the error total and the pattern state, and selects `ST_IDLE`.
- R2: In `ST_IDLE`, with no start, `dout` equals the `rx_word` value of the previous clock edge (one register of latency).
- R3: With `bist_en` high and `link_locked` low, no test starts. Data keeps passing through. The seed is taken only on the first edge where both inputs are high.
- R4: On the seeding edge the pattern state is loaded from `rx_word[6:0]`. A value of zero is replaced by 7'h7F. `dout` is zero for that cycle.
- R5: On each later checking edge the pattern state s advances to {s[5:0], s[6]^s[5]}. The expected word bit i equals bit (i mod 7) of the advanced state.
- R6: In map mode (`mode_cnt` low), `dout` after each checking edge equals `rx_word` XOR the expected word.
- R7: In count mode (`mode_cnt` high), `dout[7:0]` shows the running total of mismatched bits, including the current word, and `dout[23:8]` is zero. The total accumulates in both modes.
- R8: The running total saturates at 255.
- R9: `pass_ok` falls after the first checking edge that has any mismatch. It stays low while the test runs.
- R10: A `stop` transition sets `pass_ok` high, clears the total and resumes pass-through.
- R11: `dout_oe` and `clk_oe` are high exactly when `link_locked` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| link_locked | input | 1 | Receiver lock indication |
| bist_en | input | 1 | Self-test enable |
| mode_cnt | input | 1 | 0: per-bit error map, 1: accumulated count |
| rx_word | input | 24 | Received parallel word |
| dout | output | 24 | Data, error map or count |
| dout_oe | output | 1 | Data output driver enable |
| clk_oe | output | 1 | Clock output driver enable |
| pass_ok | output | 1 | High while no error has been seen |

## Verification
The hardest condition to reach from the ports is the saturated total, because it needs more than 255 mismatched bits. The bench gets there by sending pattern words with all 24 bits inverted for eleven cycles, which is 264 errors. Reaching a precise seed is also indirect. The bench computes each expected word with its own generator model, seeded from the word it drove on the seeding edge. It also drives a zero seed to exercise the replacement value.

// File: rtl/bist_pkg.sv
package bist_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_CHECK = 1'b1
    } bist_state_t;
endpackage

// File: rtl/bist_prbs7.sv
module bist_prbs7 #(
    parameter int WORD_W = 24,
    parameter int LFSR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [LFSR_W-1:0] seed_bits,
    output logic [WORD_W-1:0] expect_word
);
    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] lfsr_step;

    // taps for x^7 + x^6 + 1
    assign lfsr_step = {lfsr_q[LFSR_W-2:0], lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_W-2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= '1;
        end else if (load) begin
            lfsr_q <= (seed_bits == '0) ? '1 : seed_bits;
        end else if (adv) begin
            lfsr_q <= lfsr_step;
        end
    end

    for (genvar i = 0; i < WORD_W; i++) begin : g_spread
        assign expect_word[i] = lfsr_step[i % LFSR_W];
    end
endmodule

// File: rtl/bist_err_count.sv
module bist_err_count #(
    parameter int WORD_W = 24,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              acc,
    input  logic [WORD_W-1:0] err_vec,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_nxt
);
    localparam int PC_W  = $clog2(WORD_W + 1);
    localparam int SUM_W = CNT_W + PC_W;
    localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

    logic [PC_W-1:0]  pop;
    logic [SUM_W-1:0] sum;

    always_comb begin
        pop = '0;
        for (int i = 0; i < WORD_W; i++) begin
            pop = pop + PC_W'(err_vec[i]);
        end
        sum = SUM_W'(cnt_q) + SUM_W'(pop);
        cnt_nxt = (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (acc) begin
            cnt_q <= cnt_nxt;
        end
    end
endmodule

// File: rtl/bist_rx_checker.sv
module bist_rx_checker
    import bist_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int CNT_W  = 8,
    parameter int LFSR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_locked,
    input  logic              bist_en,
    input  logic              mode_cnt,
    input  logic [WORD_W-1:0] rx_word,
    output logic [WORD_W-1:0] dout,
    output logic              dout_oe,
    output logic              clk_oe,
    output logic              pass_ok
);
    localparam int HI_W = WORD_W - CNT_W;

    bist_state_t state_q, state_d;
    logic              go;
    logic              do_seed;
    logic              do_check;
    logic              in_check;
    logic [WORD_W-1:0] expect_word;
    logic [WORD_W-1:0] err_vec;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nxt;

    assign go       = bist_en && link_locked;
    assign in_check = (state_q == ST_CHECK);
    assign do_seed  = (state_q == ST_IDLE) && go;
    assign do_check = in_check && go;
    assign err_vec  = do_check ? (rx_word ^ expect_word) : '0;

    bist_prbs7 #(.WORD_W(WORD_W), .LFSR_W(LFSR_W)) u_prbs (
        .clk        (clk),
        .rst        (rst),
        .load       (do_seed),
        .adv        (do_check),
        .seed_bits  (rx_word[LFSR_W-1:0]),
        .expect_word(expect_word)
    );

    bist_err_count #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (!go),
        .acc    (do_check),
        .err_vec(err_vec),
        .cnt_q  (cnt_q),
        .cnt_nxt(cnt_nxt)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go)  state_d = ST_CHECK;
            ST_CHECK: if (!go) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout    <= '0;
            pass_ok <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    dout    <= go ? '0 : rx_word;
                    pass_ok <= 1'b1;
                end
                ST_CHECK: begin
                    if (go) begin
                        dout <= mode_cnt ? {{HI_W{1'b0}}, cnt_nxt} : err_vec;
                        if (err_vec != '0) pass_ok <= 1'b0;
                    end else begin
                        dout    <= rx_word;
                        pass_ok <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign dout_oe = link_locked;
    assign clk_oe  = link_locked;
endmodule

// File: rtl/bist_rx_checker_sva.sv
module bist_rx_checker_sva #(
    parameter int WORD_W = 24,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              link_locked,
    input logic              bist_en,
    input logic              mode_cnt,
    input logic [WORD_W-1:0] rx_word,
    input logic [WORD_W-1:0] dout,
    input logic              pass_ok,
    input logic              in_check,
    input logic [CNT_W-1:0]  cnt_q
);
    logic go;
    assign go = bist_en && link_locked;

    assert_passthru_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!go) && $past(!in_check)) |-> dout == $past(rx_word));

    assert_hi_zero_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(in_check && go && mode_cnt)) |-> dout[WORD_W-1:CNT_W] == '0);

    assert_total_grows_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(in_check && go)) |-> cnt_q >= $past(cnt_q));

    assert_pass_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (!pass_ok && go) |=> !pass_ok);

    assert_pass_restore_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!go)) |-> (pass_ok && cnt_q == '0));
endmodule

bind bist_rx_checker bist_rx_checker_sva #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .link_locked(link_locked),
    .bist_en    (bist_en),
    .mode_cnt   (mode_cnt),
    .rx_word    (rx_word),
    .dout       (dout),
    .pass_ok    (pass_ok),
    .in_check   (in_check),
    .cnt_q      (cnt_q)
);

// File: tb/sim_bist_rx_checker.sv
module sim_bist_rx_checker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_locked = 1'b0;
    logic        bist_en = 1'b0;
    logic        mode_cnt = 1'b0;
    logic [23:0] rx_word = '0;
    logic [23:0] dout;
    logic        dout_oe, clk_oe, pass_ok;

    int checks = 0;
    int errors = 0;
    logic [6:0] m_state;
    int         m_total;

    always #5 clk = ~clk;

    bist_rx_checker u0 (
        .clk(clk), .rst(rst), .link_locked(link_locked), .bist_en(bist_en),
        .mode_cnt(mode_cnt), .rx_word(rx_word), .dout(dout),
        .dout_oe(dout_oe), .clk_oe(clk_oe), .pass_ok(pass_ok)
    );

    function automatic logic [6:0] step(logic [6:0] s);
        return {s[5:0], s[6] ^ s[5]};
    endfunction

    function automatic logic [23:0] expand(logic [6:0] s);
        logic [23:0] w;
        for (int i = 0; i < 24; i++) w[i] = s[i % 7];
        return w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [23:0] w);
        @(negedge clk);
        rx_word = w;
        @(posedge clk);
        #2;
    endtask

    task automatic start(logic [23:0] seed);
        @(negedge clk);
        bist_en = 1'b1; link_locked = 1'b1;
        rx_word = seed;
        @(posedge clk);
        #2;
        m_state = (seed[6:0] == 7'd0) ? 7'h7F : seed[6:0];
        m_total = 0;
        chk("R4 seed output", dout, 24'h0);
    endtask

    task automatic send(logic [23:0] flip, string req);
        logic [23:0] e;
        int pc;
        m_state = step(m_state);
        e = expand(m_state);
        drive(e ^ flip);
        pc = $countones(flip);
        m_total = (m_total + pc > 255) ? 255 : m_total + pc;
        if (mode_cnt) chk(req, dout, 32'(m_total));
        else          chk(req, dout, flip);
    endtask

    task automatic stop();
        @(negedge clk);
        bist_en = 1'b0;
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #2;
        chk("R1 dout", dout, 0);
        chk("R1 pass", pass_ok, 1);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_passthru();
        drive(24'hA5C3_1E);
        chk("R2 pass-through a", dout, 24'hA5C31E);
        drive(24'h00FF00);
        chk("R2 pass-through b", dout, 24'h00FF00);
    endtask

    task automatic t_no_lock();
        @(negedge clk);
        bist_en = 1'b1; link_locked = 1'b0;
        chk("R11 oe low", {dout_oe, clk_oe}, 2'b00);
        drive(24'h123456);
        chk("R3 idle without lock", dout, 24'h123456);
        start(24'h000035);
        send(24'h0, "R3 seed from locked word");
        chk("R11 oe high", {dout_oe, clk_oe}, 2'b11);
        stop();
    endtask

    task automatic t_map();
        mode_cnt = 1'b0;
        start(24'hFFFF2A);
        send(24'h0, "R5 clean word");
        send(24'h0, "R5 clean word 2");
        send(24'h800001, "R6 map two bits");
        chk("R9 pass low", pass_ok, 0);
        send(24'h0, "R6 map clean");
        chk("R9 pass sticky", pass_ok, 0);
        stop();
        chk("R10 pass restored", pass_ok, 1);
        start(24'h000000);
        send(24'h0, "R4 zero seed");
        send(24'h0F0000, "R6 map zero seed");
        stop();
    endtask

    task automatic t_count();
        mode_cnt = 1'b0;
        start(24'h000011);
        send(24'h000007, "R7 accumulate in map");
        mode_cnt = 1'b1;
        send(24'h0C0000, "R7 count mode");
        send(24'h0, "R7 count hold");
        for (int k = 0; k < 11; k++) send(24'hFFFFFF, "R8 saturate");
        chk("R8 at max", dout, 24'h0000FF);
        stop();
        start(24'h000044);
        send(24'h000100, "R10 total cleared");
        stop();
        mode_cnt = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_passthru();
        t_no_lock();
        t_map();
        t_count();
        t_reset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule